// File: doc/BRIEF.md
# Taylor-Corrected Complex Oscillator

This block generates a complex sinusoid (an in-phase and a quadrature sample per clock) from a 32-bit frequency word. A running phase register advances by the frequency word on every enabled clock. The upper 11 bits of the sampled phase pick one entry from a full-period sine table and one from a full-period cosine table. The 21 lower bits are not discarded. They are turned into a small angle, and its sine and cosine are approximated to second order. The angle-sum identities then combine both parts into cos(a+b) and sin(a+b).

This removes the periodic error that plain truncation leaves in the output. The block suits mixers and down-converters that need a clean spectrum together with fine frequency resolution. The output is a stream of samples: each enabled clock cycle yields one sample, which appears five register stages later with a valid strobe. When `en` is low, the phase holds and no sample is produced. Samples are 16-bit signed, with a full scale of 32767.

Top module: `nco_taylor_iq`

## Requirements
- R1: A synchronous reset clears the phase register to zero and drives `out_i`, `out_q` and `out_valid` to zero. This applies whether reset is asserted at start-up or in the middle of operation.
- R2: On each rising edge where `en` is high, the current phase is taken as the sample phase and the phase register advances by `fcw` modulo 2^32. When `en` is low, the phase register holds its value.
- R3: `out_valid` is high exactly in the cycle that follows the fifth rising edge counted from, and including, the edge that captured `en` high. It is low otherwise, so the valid pattern repeats the enable pattern delayed by five stages.
- R4: After reset with `fcw` equal to zero, every sample has `out_i` = 32767 and `out_q` = 0.
- R5: For a sample phase p, `out_i` lies within 2 LSB of round(32767·cos(2πp/2^32)) and `out_q` within 2 LSB of round(32767·sin(2πp/2^32)). This holds for any value of the low 21 phase bits.
- R6: For a sample phase whose low 21 bits are zero and whose top 11 bits are k, `out_i` equals round(32767·cos(2πk/2048)) and `out_q` equals round(32767·sin(2πk/2048)) exactly. This holds for all 2048 values of k.
- R7: The outputs saturate to the symmetric range −32767 to +32767 and never leave it.
- R8: In any cycle where `out_valid` is low, `out_i` and `out_q` keep the values of the last valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce one sample and advance the phase this cycle |
| fcw | input | 32 | Phase increment per enabled cycle (unsigned, modulo 2^32) |
| out_i | output | 16 | Cosine sample, two's complement |
| out_q | output | 16 | Sine sample, two's complement |
| out_valid | output | 1 | High when `out_i`/`out_q` carry a new sample |

## Verification
The hardest case to reach is a sample phase whose low 21 bits are almost all ones. There the dropped phase is close to one whole table step, so the correction term is at its largest and any scaling or sign error in it shows up clearly. The stimulus gets there with a directed increment of 2^21−1, which walks the fine field downward through every table entry. Random increments with their low bits forced high do the same, mixed with random enable gaps. A second directed increment of exactly 2^21 steps through every table entry with a zero fine field, where the outputs must match the table values exactly.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam real TWO_PI = 6.283185307179586;

    typedef enum logic {
        WAVE_SIN = 1'b0,
        WAVE_COS = 1'b1
    } wave_e;

    // One rounded point of a full-period table of the given depth.
    function automatic int wave_point(int idx, int depth, int amp, wave_e kind);
        real ang;
        real v;
        ang = TWO_PI * real'(idx) / real'(depth);
        v   = (kind == WAVE_COS) ? $cos(ang) : $sin(ang);
        return $rtoi($floor(v * real'(amp) + 0.5));
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] fcw,
    output logic [PHASE_W-1:0] acc_q,
    output logic [PHASE_W-1:0] smp_phase_q,
    output logic               smp_vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            smp_phase_q <= '0;
            smp_vld_q   <= 1'b0;
        end else begin
            smp_vld_q <= en;
            if (en) begin
                smp_phase_q <= acc_q;
                acc_q       <= acc_q + fcw;
            end
        end
    end

endmodule

// File: rtl/nco_trig_rom.sv
module nco_trig_rom
    import nco_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] sin_q,
    output logic signed [SAMP_W-1:0] cos_q
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

    logic signed [SAMP_W-1:0] sin_tab [DEPTH];
    logic signed [SAMP_W-1:0] cos_tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        assign sin_tab[g] = SAMP_W'(wave_point(g, DEPTH, AMP, WAVE_SIN));
        assign cos_tab[g] = SAMP_W'(wave_point(g, DEPTH, AMP, WAVE_COS));
    end

    always_ff @(posedge clk) begin
        sin_q <= sin_tab[addr];
        cos_q <= cos_tab[addr];
    end

endmodule

// File: rtl/nco_fine_angle.sv
module nco_fine_angle
    import nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int FINE_W  = 21
) (
    input  logic                clk,
    input  logic [FINE_W-1:0]   fine,
    output logic [FINE_W+2:0]   ang_q,
    output logic [FINE_W+2:0]   ang_qq,
    output logic [PHASE_W:0]    cosb_q
);

    // Angle is kept in units of 2^-PHASE_W radians.
    localparam int KS   = 16;
    localparam int KW   = KS + 3;
    localparam int BW   = FINE_W + 3;
    localparam int MW   = FINE_W + KW;
    localparam int SQW  = 2 * BW;
    localparam int KC   = $rtoi(TWO_PI * real'(1 << KS) + 0.5);

    logic [MW-1:0]      scaled;
    logic [SQW-1:0]     sq;
    logic [PHASE_W:0]   half_sq;

    always_comb begin
        scaled  = MW'(fine) * MW'(KC) + MW'(1 << (KS - 1));
        sq      = SQW'(ang_q) * SQW'(ang_q) + (SQW'(1) << PHASE_W);
        half_sq = (PHASE_W+1)'(sq >> (PHASE_W + 1));
    end

    always_ff @(posedge clk) begin
        ang_q  <= scaled[KS +: BW];
        ang_qq <= ang_q;
        cosb_q <= {1'b1, {PHASE_W{1'b0}}} - half_sq;
    end

endmodule

// File: rtl/nco_angle_sum.sv
module nco_angle_sum #(
    parameter int SAMP_W  = 16,
    parameter int PHASE_W = 32,
    parameter int BW      = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_in,
    input  logic signed [SAMP_W-1:0] sin_a,
    input  logic signed [SAMP_W-1:0] cos_a,
    input  logic [BW-1:0]            ang_b,
    input  logic [PHASE_W:0]         cos_b,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_vld
);

    localparam int XW = SAMP_W + PHASE_W + 4;
    localparam logic signed [XW-1:0] RND  = XW'(64'd1 << (PHASE_W - 1));
    localparam logic signed [XW-1:0] MAXV = XW'((64'd1 << (SAMP_W - 1)) - 64'd1);

    logic signed [XW-1:0] cb_s, b_s, ca_s, sa_s;
    logic signed [XW-1:0] sum_i, sum_q, sh_i, sh_q;

    function automatic logic signed [SAMP_W-1:0] clamp(logic signed [XW-1:0] v);
        if (v > MAXV)
            return MAXV[SAMP_W-1:0];
        else if (v < -MAXV)
            return (-MAXV);
        else
            return v[SAMP_W-1:0];
    endfunction

    always_comb begin
        cb_s  = XW'($signed({1'b0, cos_b}));
        b_s   = XW'($signed({1'b0, ang_b}));
        ca_s  = XW'(cos_a);
        sa_s  = XW'(sin_a);
        sum_i = ca_s * cb_s - sa_s * b_s + RND;
        sum_q = sa_s * cb_s + ca_s * b_s + RND;
        sh_i  = sum_i >>> PHASE_W;
        sh_q  = sum_q >>> PHASE_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_i   <= '0;
            out_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= vld_in;
            if (vld_in) begin
                out_i <= clamp(sh_i);
                out_q <= clamp(sh_q);
            end
        end
    end

endmodule

// File: rtl/nco_taylor_iq.sv
module nco_taylor_iq #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 11,
    parameter int SAMP_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [PHASE_W-1:0]       fcw,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_valid
);

    localparam int FINE_W = PHASE_W - ADDR_W;
    localparam int BW     = FINE_W + 3;

    logic [PHASE_W-1:0]       acc_q;
    logic [PHASE_W-1:0]       ph1;
    logic                     vld1;
    logic signed [SAMP_W-1:0] sin2, cos2, sin3, cos3, sin4, cos4;
    logic [FINE_W-1:0]        fine2;
    logic                     vld2, vld3, vld4;
    logic [BW-1:0]            ang3, ang4;
    logic [PHASE_W:0]         cosb4;

    // Stage 1: phase register and sample phase
    nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .fcw         (fcw),
        .acc_q       (acc_q),
        .smp_phase_q (ph1),
        .smp_vld_q   (vld1)
    );

    // Stage 2: coarse table lookup
    nco_trig_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
        .clk   (clk),
        .addr  (ph1[PHASE_W-1 -: ADDR_W]),
        .sin_q (sin2),
        .cos_q (cos2)
    );

    // Stages 3 and 4: fine angle and its cosine
    nco_fine_angle #(.PHASE_W(PHASE_W), .FINE_W(FINE_W)) u_fine (
        .clk    (clk),
        .fine   (fine2),
        .ang_q  (ang3),
        .ang_qq (ang4),
        .cosb_q (cosb4)
    );

    always_ff @(posedge clk) begin
        fine2 <= ph1[FINE_W-1:0];
        sin3  <= sin2;
        cos3  <= cos2;
        sin4  <= sin3;
        cos4  <= cos3;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld2 <= 1'b0;
            vld3 <= 1'b0;
            vld4 <= 1'b0;
        end else begin
            vld2 <= vld1;
            vld3 <= vld2;
            vld4 <= vld3;
        end
    end

    // Stage 5: angle-sum combine, round and saturate
    nco_angle_sum #(.SAMP_W(SAMP_W), .PHASE_W(PHASE_W), .BW(BW)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .vld_in  (vld4),
        .sin_a   (sin4),
        .cos_a   (cos4),
        .ang_b   (ang4),
        .cos_b   (cosb4),
        .out_i   (out_i),
        .out_q   (out_q),
        .out_vld (out_valid)
    );

endmodule

// File: rtl/nco_taylor_iq_chk.sv
module nco_taylor_iq_chk #(
    parameter int PHASE_W = 32,
    parameter int SAMP_W  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [PHASE_W-1:0]       fcw,
    input logic [PHASE_W-1:0]       acc,
    input logic signed [SAMP_W-1:0] out_i,
    input logic signed [SAMP_W-1:0] out_q,
    input logic                     out_valid
);

    localparam longint FS  = (longint'(1) << (SAMP_W - 1)) - 1;
    localparam longint FS2 = FS * FS;
    localparam longint TOL = 8 * FS;

    logic [2:0]         age;
    logic signed [63:0] rad2;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 3'd7)
            age <= age + 3'd1;
    end

    always_comb rad2 = longint'(out_i) * longint'(out_i) + longint'(out_q) * longint'(out_q);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && !out_valid && out_i == '0 && out_q == '0));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && $past(en)) |-> acc == $past(acc) + $past(fcw));

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && !$past(en)) |-> $stable(acc));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd5) |-> out_valid == $past(en, 5));

    assert_unit_circle_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rad2 > FS2 - TOL && rad2 < FS2 + TOL));

    assert_range_R7: assert property (@(posedge clk) disable iff (rst)
        out_i >= -SAMP_W'(FS) && out_q >= -SAMP_W'(FS));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind nco_taylor_iq nco_taylor_iq_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .fcw       (fcw),
    .acc       (acc_q),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_valid (out_valid)
);

// File: tb/nco_taylor_iq_tb.sv
`timescale 1ns/1ps
module nco_taylor_iq_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        fcw = '0;
    logic signed [15:0] out_i, out_q;
    logic               out_valid;

    int          errors = 0;
    int          checks = 0;
    bit          done   = 1'b0;
    logic [31:0] mdl_acc = '0;
    logic [31:0] phq[$];
    logic [4:0]  hist = '0;
    logic signed [15:0] last_i = '0, last_q = '0;
    string       tag_fine = "R5";

    always #2 clk = ~clk;

    nco_taylor_iq u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .fcw       (fcw),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_valid (out_valid)
    );

    function automatic int ref_val(logic [31:0] p, bit want_cos);
        real ang;
        ang = 6.283185307179586 * real'(p) / 4294967296.0;
        return $rtoi($floor(32767.0 * (want_cos ? $cos(ang) : $sin(ang)) + 0.5));
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic observe();
        logic [31:0] p;
        int ei, eq;
        check(out_valid == hist[4], "R3", "valid strobe", int'(out_valid), int'(hist[4]));
        if (out_valid) begin
            if (phq.size() == 0) begin
                check(1'b0, "R3", "unexpected sample", 1, 0);
            end else begin
                p  = phq.pop_front();
                ei = ref_val(p, 1'b1);
                eq = ref_val(p, 1'b0);
                if (p == 32'd0) begin
                    check(out_i == 16'sd32767, "R4", "zero phase I", int'(out_i), 32767);
                    check(out_q == 16'sd0, "R4", "zero phase Q", int'(out_q), 0);
                end else if (p[20:0] == 21'd0) begin
                    check(int'(out_i) == ei, "R6", "table I", int'(out_i), ei);
                    check(int'(out_q) == eq, "R6", "table Q", int'(out_q), eq);
                end else begin
                    check(absi(int'(out_i) - ei) <= 2, tag_fine, "corrected I", int'(out_i), ei);
                    check(absi(int'(out_q) - eq) <= 2, tag_fine, "corrected Q", int'(out_q), eq);
                end
                check(out_i >= -16'sd32767 && out_q >= -16'sd32767, "R7", "range",
                      (out_i < out_q) ? int'(out_i) : int'(out_q), -32767);
            end
        end else begin
            check(out_i == last_i, "R8", "idle hold I", int'(out_i), int'(last_i));
            check(out_q == last_q, "R8", "idle hold Q", int'(out_q), int'(last_q));
        end
        last_i = out_i;
        last_q = out_q;
    endtask

    task automatic cycle(input bit e, input logic [31:0] f);
        @(negedge clk);
        observe();
        en  = e;
        fcw = f;
        if (e) begin
            phq.push_back(mdl_acc);
            mdl_acc = mdl_acc + f;
        end
        hist = {hist[3:0], e};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
            check(out_i == 16'sd0 && out_q == 16'sd0, "R1", "reset outputs", int'(out_i), 0);
        end
        mdl_acc = '0;
        phq.delete();
        hist   = '0;
        last_i = '0;
        last_q = '0;
        rst    = 1'b0;
    endtask

    task automatic drain();
        repeat (8) cycle(1'b0, 32'd0);
        check(phq.size() == 0, "R3", "missing samples", phq.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        do_reset();

        // R4: zero frequency word after reset
        repeat (8) cycle(1'b1, 32'd0);
        drain();

        // R6: one full table step per sample, all 2048 entries
        repeat (2048 + 4) cycle(1'b1, 32'h0020_0000);
        drain();

        // R5: fine field just below a full step, largest correction
        repeat (3000) cycle(1'b1, 32'h001F_FFFF);
        drain();

        // R2: negative frequency, wrap-around and enable gaps
        tag_fine = "R2";
        for (int n = 0; n < 2000; n++)
            cycle((n % 3) != 1, 32'hFFFD_1235);
        drain();
        tag_fine = "R5";

        // R5, R3, R8: random frequency words and enable patterns
        for (int blk = 0; blk < 800; blk++) begin
            logic [31:0] f;
            int len;
            case ($urandom % 3)
                0:       f = $urandom;
                1:       f = $urandom | 32'h001F_FF00;
                default: f = $urandom % 32'h0004_0000;
            endcase
            len = 1 + ($urandom % 40);
            for (int k = 0; k < len; k++)
                cycle(($urandom % 4) != 0, f);
        end
        drain();

        // R1: reset in the middle of operation clears the phase
        repeat (20) cycle(1'b1, 32'h1357_9BDF);
        do_reset();
        repeat (6) cycle(1'b1, 32'd0);
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule